// File: doc/BRIEF.md
# Serial ADC Frame Readout Controller

This block is the host side of a three-wire link to a 10-bit serial converter. The three wires are an active-low select, a serial clock and a returning data line. A start request lowers the select, and that edge also makes the converter sample its input. The block then runs a number of serial clock cycles taken from a divider of the system clock. From the 16-bit word that comes back it keeps the ten data bits. The two leading zeros and the four pad zeros are discarded.

The serial clock rests high, so the first edge after the select falls is a falling edge. The converter moves one bit onto the data line after each falling edge. The controller samples that line in the system cycle in which it drives the serial clock high again.

The frame length is read from an input when the frame starts. The select is raised only after the rising edge that ends the conversion, so a frame can never be shorter than 11 clocks. Once the select is high, a programmable quiet interval runs before the next frame may start. Start requests that arrive while a frame or the quiet interval is running are remembered and serviced afterwards.

Top module: `adc_frame_ctrl`

## Requirements
- R1: After reset, or while rst_ni is low, cs_no and sclk_o are high, and valid_o and busy_o are low.
- R2: The number of serial clock cycles in a frame is frame_len_i as read when the frame starts, limited to the range 11 to 16. Values below 11 give 11 and values above 16 give 16. Each cycle is one falling edge followed by one rising edge.
- R3: sclk_o is high whenever cs_no is high. Each low and each high phase of sclk_o lasts HALF_DIV system clocks, and the first transition after cs_no falls is a falling edge.
- R4: sdo_i is sampled in the system cycle that drives sclk_o high. The samples that follow falling edges 2 to 11 form the result, first sample as bit 9, so data_o equals bits 13:4 of the 16-bit word.
- R5: After the rising edge that follows falling edge 11, valid_o pulses high for exactly one cycle. data_o carries the new result in that cycle and changes at no other time.
- R6: cs_no never rises before the 11th rising edge of sclk_o in a frame. It rises after the last rising edge of the frame.
- R7: After cs_no rises it stays high for at least QUIET_CYC system clocks before it may fall again.
- R8: A start_i pulse that arrives while busy_o is high is kept, and one extra frame runs once the quiet interval ends. Any number of such pulses during one frame give exactly one extra frame.
- R9: busy_o is high from the cycle cs_no falls until the quiet interval after that frame has ended.
- R10: The level of sdo_i after the select edge, after falling edge 1 and after falling edges 12 to 16 has no effect on data_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request for one conversion frame |
| frame_len_i | input | LEN_W (5) | Serial clock cycles per frame, limited to 11..16 |
| sdo_i | input | 1 | Serial data from the converter |
| cs_no | output | 1 | Converter select, active low |
| sclk_o | output | 1 | Serial clock to the converter, rests high |
| busy_o | output | 1 | A frame or its quiet interval is in progress |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| data_o | output | DATA_W (10) | Latest 10-bit conversion result |

## Verification
The case hardest to reach from the ports is a start request that lands while the previous frame is still running, or while its quiet interval is running. Catching it means timing the pulse against the select line rather than against a fixed cycle count. The bench therefore watches cs_no and raises start_i both in the middle of a frame and just after the select rises. It also sends a burst of requests within one frame, then counts how many frames follow and measures how long the select stays high between them. A behavioural converter model drives ones into the lead and pad positions, so that a capture window shifted by a single edge shows up in data_o.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_QUIET
  } seq_state_e;

endpackage

// File: rtl/adc_half_timer.sv
module adc_half_timer #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R3
  half_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(HALF_DIV - 1));

endmodule

// File: rtl/adc_quiet_timer.sv
module adc_quiet_timer #(
  parameter int QUIET_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic expired_o
);
  localparam int QW = $clog2(QUIET_CYC + 1);

  logic [QW-1:0] cnt_q;

  assign expired_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (arm_i)       cnt_q <= QW'(QUIET_CYC);
    else if (!expired_o)  cnt_q <= cnt_q - 1'b1;
  end

  // R7
  quiet_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> !expired_o);

endmodule

// File: rtl/adc_sdo_capture.sv
module adc_sdo_capture #(
  parameter int DATA_W    = 10,
  parameter int LEAD_BITS = 2,
  parameter int LEN_W     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [LEN_W-1:0]  edge_idx_i,
  input  logic              sdo_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int FIRST = LEAD_BITS;
  localparam int LAST  = LEAD_BITS + DATA_W - 1;

  logic [DATA_W-1:0] sh_q;
  logic              in_win, at_last;

  assign in_win  = sample_i && (edge_idx_i >= LEN_W'(FIRST)) && (edge_idx_i <= LEN_W'(LAST));
  assign at_last = sample_i && (edge_idx_i == LEN_W'(LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= at_last;
      if (in_win)  sh_q   <= {sh_q[DATA_W-2:0], sdo_i};
      if (at_last) data_o <= {sh_q[DATA_W-2:0], sdo_i};
    end
  end

  // R5
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R5
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_o) |-> valid_o);

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int LEAD_BITS = 2,
  parameter int FRAME_MAX = 16,
  parameter int HALF_DIV  = 2,
  parameter int QUIET_CYC = 8,
  parameter int LEN_W     = $clog2(FRAME_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  input  logic              sdo_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  // conversion ends on the rise after the last data falling edge
  localparam int FRAME_MIN = LEAD_BITS + DATA_W - 1;

  seq_state_e       state_q;
  logic [LEN_W-1:0] fall_q, len_q, len_sel;
  logic             pend_q, cs_n_q, sclk_q;
  logic             launch, half_tick, run, rise_now, last_rise, q_expired;

  always_comb begin
    if (frame_len_i < LEN_W'(FRAME_MIN))      len_sel = LEN_W'(FRAME_MIN);
    else if (frame_len_i > LEN_W'(FRAME_MAX)) len_sel = LEN_W'(FRAME_MAX);
    else                                      len_sel = frame_len_i;
  end

  assign launch    = (state_q == ST_IDLE) && (pend_q || start_i);
  assign run       = (state_q == ST_SETUP) || (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign rise_now  = (state_q == ST_LOW) && half_tick;
  assign last_rise = (state_q == ST_HIGH) && half_tick && (fall_q == len_q);

  adc_half_timer #(.HALF_DIV(HALF_DIV)) u_half (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (half_tick)
  );

  adc_quiet_timer #(.QUIET_CYC(QUIET_CYC)) u_quiet (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (last_rise),
    .expired_o (q_expired)
  );

  adc_sdo_capture #(.DATA_W(DATA_W), .LEAD_BITS(LEAD_BITS), .LEN_W(LEN_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (rise_now),
    .edge_idx_i (fall_q),
    .sdo_i      (sdo_i),
    .data_o     (data_o),
    .valid_o    (valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fall_q  <= '0;
      len_q   <= LEN_W'(FRAME_MIN);
      pend_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b1;
    end else begin
      pend_q <= launch ? 1'b0 : (pend_q | start_i);
      unique case (state_q)
        ST_IDLE: if (launch) begin
          state_q <= ST_SETUP;
          cs_n_q  <= 1'b0;
          fall_q  <= '0;
          len_q   <= len_sel;
        end
        ST_SETUP: if (half_tick) begin
          state_q <= ST_LOW;
          sclk_q  <= 1'b0;
          fall_q  <= LEN_W'(1);
        end
        ST_LOW: if (half_tick) begin
          state_q <= ST_HIGH;
          sclk_q  <= 1'b1;
        end
        ST_HIGH: if (half_tick) begin
          if (fall_q == len_q) begin
            state_q <= ST_QUIET;
            cs_n_q  <= 1'b1;
          end else begin
            state_q <= ST_LOW;
            sclk_q  <= 1'b0;
            fall_q  <= fall_q + 1'b1;
          end
        end
        ST_QUIET: if (q_expired) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no  = cs_n_q;
  assign sclk_o = sclk_q;
  assign busy_o = (state_q != ST_IDLE);

  // independent count of serial clock rises inside a frame
  logic             sclk_prev_q;
  logic [LEN_W-1:0] chk_rises_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b1;
      chk_rises_q <= '0;
    end else begin
      sclk_prev_q <= sclk_q;
      if (cs_n_q)                    chk_rises_q <= '0;
      else if (sclk_q && !sclk_prev_q) chk_rises_q <= chk_rises_q + 1'b1;
    end
  end

  // R6
  cs_early_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> chk_rises_q >= LEN_W'(FRAME_MIN));

  // R2
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> chk_rises_q == len_q);

  // R2
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> (len_q >= LEN_W'(FRAME_MIN)) && (len_q <= LEN_W'(FRAME_MAX)));

  // R3
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);

  // R7
  quiet_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(q_expired));

  // R9
  busy_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);

endmodule

// File: tb/adc_frame_ctrl_tb.sv
module adc_frame_ctrl_tb;
  localparam int HALF  = 2;
  localparam int QUIET = 6;
  localparam int LW    = 5;
  localparam int NV    = 8;

  // {sample, frame_len_i, expected clocks, junk in lead/pad}
  localparam logic [20:0] VEC [NV] = '{
    {10'h3FF, 5'd16, 5'd16, 1'b0},
    {10'h000, 5'd11, 5'd11, 1'b1},
    {10'h2AA, 5'd13, 5'd13, 1'b1},
    {10'h155, 5'd5,  5'd11, 1'b0},
    {10'h201, 5'd20, 5'd16, 1'b1},
    {10'h0F0, 5'd0,  5'd11, 1'b1},
    {10'h3C3, 5'd31, 5'd16, 1'b0},
    {10'h001, 5'd12, 5'd12, 1'b1}
  };

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [LW-1:0] flen = 5'd16;
  logic          sdo, cs_no, sclk_o, busy_o, valid_o;
  logic [9:0]    data_o;

  always #5 clk = ~clk;

  adc_frame_ctrl #(.HALF_DIV(HALF), .QUIET_CYC(QUIET)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .frame_len_i(flen),
    .sdo_i(sdo), .cs_no(cs_no), .sclk_o(sclk_o), .busy_o(busy_o),
    .valid_o(valid_o), .data_o(data_o)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] word = '0;
  logic        junk = 1'b0;
  int mfalls = 16, mrises = 0, last_rises = 0, last_falls = 0;
  int frames = 0, gap = 1000, last_gap = 1000, lo_run = 0, vcnt = 0;
  logic lo_bad = 1'b0, prev_cs = 1'b1, prev_sclk = 1'b1;
  logic [9:0] last_data = '0;

  // converter model: new bit after select fall and after each sclk fall
  assign sdo = cs_no ? 1'b0 : ((mfalls <= 15) ? word[15 - mfalls] : junk);

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cs = 1'b1; prev_sclk = 1'b1; mfalls = 16; lo_run = 0;
    end else begin
      if (prev_cs && !cs_no) begin
        mfalls = 0; mrises = 0; last_gap = gap; lo_bad = 1'b0; lo_run = 0;
      end
      if (!cs_no && prev_sclk && !sclk_o) mfalls++;
      if (!cs_no && !prev_sclk && sclk_o) begin
        mrises++;
        if (lo_run != HALF) lo_bad = 1'b1;
        lo_run = 0;
      end
      if (!cs_no && !sclk_o) lo_run++;
      if (!prev_cs && cs_no) begin
        last_rises = mrises; last_falls = mfalls; frames++; gap = 0;
      end
      if (cs_no) gap++;
      if (valid_o) begin vcnt++; last_data = data_o; end
      prev_cs = cs_no; prev_sclk = sclk_o;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic load_word(input logic [9:0] s, input logic j);
    junk = j;
    word = j ? {2'b11, s, 4'hF} : {2'b00, s, 4'h0};
  endtask

  task automatic wait_frames(input int target);
    while (frames < target) @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int f0, v0;
    repeat (3) @(negedge clk);
    // R1 during and after reset
    check(cs_no === 1'b1 && sclk_o === 1'b1, "R1", {cs_no, sclk_o}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid_o === 1'b0 && busy_o === 1'b0, "R1", {valid_o, busy_o}, 0);

    for (int i = 0; i < NV; i++) begin
      load_word(VEC[i][20:11], VEC[i][0]);
      flen = VEC[i][10:6];
      f0 = frames; v0 = vcnt;
      pulse_start();
      while (cs_no) @(negedge clk);
      check(busy_o === 1'b1, "R9", busy_o, 1);
      wait_frames(f0 + 1);
      // R4 and R10: pad/lead junk must not leak into data
      check(last_data == VEC[i][20:11], "R4 R10", last_data, VEC[i][20:11]);
      check(vcnt - v0 == 1, "R5", vcnt - v0, 1);
      check(last_rises == int'(VEC[i][5:1]), "R2", last_rises, VEC[i][5:1]);
      check(last_falls == int'(VEC[i][5:1]), "R2", last_falls, VEC[i][5:1]);
      check(last_rises >= 11, "R6", last_rises, 11);
      check(!lo_bad, "R3", lo_bad, 0);
    end

    // R8: burst of requests inside one frame gives one extra frame
    load_word(10'h1A5, 1'b1);
    flen = 5'd14;
    f0 = frames; v0 = vcnt;
    pulse_start();
    while (cs_no) @(negedge clk);
    repeat (4) @(negedge clk);
    pulse_start(); pulse_start(); pulse_start();
    wait_frames(f0 + 2);
    repeat (40) @(negedge clk);
    check(frames - f0 == 2, "R8", frames - f0, 2);
    check(vcnt - v0 == 2, "R8", vcnt - v0, 2);
    check(last_data == 10'h1A5, "R4", last_data, 10'h1A5);
    check(last_gap >= QUIET, "R7", last_gap, QUIET);

    // R8 and R7: request issued during the quiet interval
    load_word(10'h2C7, 1'b0);
    f0 = frames;
    pulse_start();
    while (frames < f0 + 1) @(negedge clk);
    check(busy_o === 1'b1, "R9", busy_o, 1);
    pulse_start();
    wait_frames(f0 + 2);
    check(frames - f0 == 2, "R8", frames - f0, 2);
    check(last_gap >= QUIET, "R7", last_gap, QUIET);
    check(last_data == 10'h2C7, "R4", last_data, 10'h2C7);

    // R1: reset in mid-frame
    pulse_start();
    while (cs_no) @(negedge clk);
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(cs_no === 1'b1 && sclk_o === 1'b1, "R1", {cs_no, sclk_o}, 3);
    check(busy_o === 1'b0 && valid_o === 1'b0, "R1", {busy_o, valid_o}, 0);
    check(data_o === 10'h000, "R1", data_o, 0);
    rst_n = 1'b1;

    // recovery after reset
    load_word(10'h36C, 1'b1);
    flen = 5'd15;
    f0 = frames;
    pulse_start();
    wait_frames(f0 + 1);
    check(last_data == 10'h36C, "R4 R10", last_data, 10'h36C);
    check(last_rises == 15, "R2", last_rises, 15);

    finish_run();
  end

endmodule